// File: doc/BRIEF.md
# ISC Command Gate with Side-Band Status Flags

This block stands between the JTAG instruction decoder of an in-system-programmable flash device and its program/erase engine. Each decoded in-system-configuration command arrives as a one-cycle request: enable, disable, clear, program, sector erase, full chip erase, verify or read. The gate checks the command against a non-volatile security bit and a set of per-sector protect bits. It then either launches the engine with one start pulse or refuses the command and raises a sticky error flag.

Two active-low side-band pins report the outcome so that a host does not have to scan status out serially. The status pin is high when the device is ready and low while work is in progress. The error pin is low while the sticky error flag is set. The pins are dormant until an enable command arrives. A mode bit carried with that enable command selects push-pull drive or open-drain drive. Open-drain drive lets several chained devices share one wired-OR line.

The controller is a four-state machine. DORMANT means the pins are undriven. READY means the pins are on and commands are accepted. LAUNCH is one cycle in which the engine start is pulsed. RUN waits for the engine busy input to fall. The transitions are:
- DORMANT to READY on an enable command.
- READY to DORMANT on a disable command.
- READY to LAUNCH on an engine command that passes the checks.
- LAUNCH to RUN unconditionally.
- RUN to READY when engine busy is low.

Top module: `isc_cmd_gate`

## Requirements
- R1: After reset or a disable command, and until an enable command (op code 0), both `stat_oe` and `err_oe` are 0. Every command other than enable is ignored in that state.
- R2: The `cmd_od` bit captured with enable selects the pin mode. In push-pull mode (0), each pin's `*_oe` is 1 and `*_o` carries the level. In open-drain mode (1), each `*_o` is 0 and `*_oe` is 1 only when the level is low.
- R3: The status level is high when READY and `sec_wr_busy` is 0. It goes low from the cycle after an accepted engine command until the cycle after engine busy is first seen low. With an engine whose busy rises the cycle after start and stays high for L cycles, status is high again L+2 cycles after the command edge. Status is also low whenever `sec_wr_busy` is 1.
- R4: An accepted engine command gives exactly one `eng_start` pulse in the cycle after it is presented. The command's op code and sector appear on `eng_op` and `eng_sector` during that pulse. The op codes are: 1 disable, 2 clear, 3 program, 4 sector erase, 5 full chip erase, 6 verify, 7 read.
- R5: If `eng_error` is 1 when an operation completes, the sticky error flag is set and the error pin is driven low. The flag stays set through later successful operations and through a repeated enable.
- R6: A clear command (2) releases the error flag. A disable command (1) releases the flag and turns the pins off.
- R7: While the security bit is set, program, sector erase, verify and read are refused: there is no start pulse and the error flag is set. A full chip erase is still accepted.
- R8: A full chip erase that completes with `eng_error` 0 clears the security bit, so a later read is accepted. If it completes with an error, the security bit stays set.
- R9: A sector erase aimed at a protected sector, or at a sector number of `SECTORS` or higher, is refused and sets the error flag. A program to a protected sector is accepted.
- R10: A command presented during LAUNCH or RUN is ignored. It gives no start pulse, and a clear presented then does not release the error flag.
- R11: Synchronous reset clears the enabled state, the error flag and the open-drain mode. It keeps the security bit and the protect bits. `cfg_load` writes those bits only while the pins are dormant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command request |
| cmd_op | input | 3 | Command op code |
| cmd_sector | input | SECT_W | Target sector of the command |
| cmd_od | input | 1 | Open-drain mode bit, captured with enable |
| cfg_load | input | 1 | Write the non-volatile configuration (dormant only) |
| cfg_secure | input | 1 | Security bit value to load |
| cfg_protect | input | SECTORS | Per-sector protect bits to load |
| eng_busy | input | 1 | Engine busy, high from the cycle after start |
| eng_error | input | 1 | Engine failure, sampled when busy is low in RUN |
| sec_wr_busy | input | 1 | Secondary array write in progress |
| eng_start | output | 1 | Engine start pulse |
| eng_op | output | 3 | Op code for the engine |
| eng_sector | output | SECT_W | Sector for the engine |
| stat_o | output | 1 | Status pin data |
| stat_oe | output | 1 | Status pin output enable |
| err_o | output | 1 | Error pin data |
| err_oe | output | 1 | Error pin output enable |

## Verification
The main gating function is exercised with a table of commands. The table mixes accepted operations, an erase of a protected sector, a program to that same protected sector, and engine-reported failures. Together these separate a refusal made by the gate from a failure reported by the engine, and show that the flag stays set until a clear. A second pass repeats every engine command with the security bit set, and then runs a failing and a succeeding chip erase, which tells apart the lock that holds from the lock that is lifted. Commands sent during LAUNCH and RUN, together with an exact count of the status low window, show that the busy window is sealed against new commands. Both pin modes are observed as a line with a pull-up, so push-pull and open-drain give the same logical level but different enables.

// File: rtl/isc_gate_pkg.sv
package isc_gate_pkg;

    typedef enum logic [2:0] {
        OP_ENABLE     = 3'd0,
        OP_DISABLE    = 3'd1,
        OP_CLEAR      = 3'd2,
        OP_PROGRAM    = 3'd3,
        OP_SECT_ERASE = 3'd4,
        OP_CHIP_ERASE = 3'd5,
        OP_VERIFY     = 3'd6,
        OP_READ       = 3'd7
    } isc_op_e;

    typedef enum logic [1:0] {
        ST_DORMANT = 2'd0,
        ST_READY   = 2'd1,
        ST_LAUNCH  = 2'd2,
        ST_RUN     = 2'd3
    } gate_state_e;

    localparam int PIN_STAT = 0;
    localparam int PIN_ERR  = 1;
    localparam int PIN_COUNT = 2;

    function automatic logic is_engine_op(isc_op_e op);
        return (op == OP_PROGRAM) || (op == OP_SECT_ERASE) || (op == OP_CHIP_ERASE) ||
               (op == OP_VERIFY) || (op == OP_READ);
    endfunction

endpackage

// File: rtl/isc_nvcfg.sv
// Non-volatile configuration holder: security lock and per-sector protect bits.
// Deliberately untouched by the block reset.
module isc_nvcfg #(
    parameter int SECTORS = 8
) (
    input  logic               clk,
    input  logic               load_en,
    input  logic               load_secure,
    input  logic [SECTORS-1:0] load_protect,
    input  logic               unlock,
    output logic               secure_q,
    output logic [SECTORS-1:0] protect_q
);

    always_ff @(posedge clk) begin
        if (load_en) begin
            secure_q  <= load_secure;
            protect_q <= load_protect;
        end else if (unlock) begin
            secure_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/isc_cmd_check.sv
// Combinational policy check of one command against lock and protection.
module isc_cmd_check
    import isc_gate_pkg::*;
#(
    parameter int SECTORS = 8,
    localparam int SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  isc_op_e            op,
    input  logic [SECT_W-1:0]  sector,
    input  logic               secure,
    input  logic [SECTORS-1:0] protect,
    output logic               wants_engine,
    output logic               refuse
);

    logic prot_hit;
    logic in_range;
    logic lock_block;
    logic erase_block;

    always_comb begin
        prot_hit = 1'b0;
        in_range = 1'b0;
        for (int i = 0; i < SECTORS; i++) begin
            if (sector == SECT_W'(i)) begin
                prot_hit = protect[i];
                in_range = 1'b1;
            end
        end
    end

    always_comb begin
        wants_engine = is_engine_op(op);
        lock_block   = secure && (op != OP_CHIP_ERASE);
        erase_block  = (op == OP_SECT_ERASE) && (prot_hit || !in_range);
        refuse       = wants_engine && (lock_block || erase_block);
    end

endmodule

// File: rtl/isc_pin_drv.sv
// One side-band pin: push-pull level or open-drain pull-down.
module isc_pin_drv (
    input  logic pins_on,
    input  logic od_mode,
    input  logic level,
    output logic pin_o,
    output logic pin_oe
);

    always_comb begin
        if (!pins_on) begin
            pin_o  = 1'b0;
            pin_oe = 1'b0;
        end else if (od_mode) begin
            pin_o  = 1'b0;
            pin_oe = !level;
        end else begin
            pin_o  = level;
            pin_oe = 1'b1;
        end
    end

endmodule

// File: rtl/isc_cmd_gate.sv
module isc_cmd_gate
    import isc_gate_pkg::*;
#(
    parameter int SECTORS = 8,
    localparam int SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [SECT_W-1:0]  cmd_sector,
    input  logic               cmd_od,
    input  logic               cfg_load,
    input  logic               cfg_secure,
    input  logic [SECTORS-1:0] cfg_protect,
    input  logic               eng_busy,
    input  logic               eng_error,
    input  logic               sec_wr_busy,
    output logic               eng_start,
    output logic [2:0]         eng_op,
    output logic [SECT_W-1:0]  eng_sector,
    output logic               stat_o,
    output logic               stat_oe,
    output logic               err_o,
    output logic               err_oe
);

    gate_state_e        state_q, state_d;
    isc_op_e            cmd_op_e;
    isc_op_e            op_q;
    logic [SECT_W-1:0]  sector_q;
    logic               err_flag_q;
    logic               od_q;
    logic               secure_q;
    logic [SECTORS-1:0] protect_q;
    logic               wants_engine;
    logic               refuse;
    logic               op_done;
    logic               unlock;
    logic               pins_on;
    logic [PIN_COUNT-1:0] pin_level;
    logic [PIN_COUNT-1:0] pin_o;
    logic [PIN_COUNT-1:0] pin_oe;

    assign cmd_op_e = isc_op_e'(cmd_op);
    assign op_done  = (state_q == ST_RUN) && !eng_busy;
    assign unlock   = op_done && !eng_error && (op_q == OP_CHIP_ERASE);

    isc_nvcfg #(.SECTORS(SECTORS)) u_nvcfg (
        .clk          (clk),
        .load_en      (cfg_load && (state_q == ST_DORMANT)),
        .load_secure  (cfg_secure),
        .load_protect (cfg_protect),
        .unlock       (unlock),
        .secure_q     (secure_q),
        .protect_q    (protect_q)
    );

    isc_cmd_check #(.SECTORS(SECTORS)) u_check (
        .op           (cmd_op_e),
        .sector       (cmd_sector),
        .secure       (secure_q),
        .protect      (protect_q),
        .wants_engine (wants_engine),
        .refuse       (refuse)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DORMANT: begin
                if (cmd_valid && (cmd_op_e == OP_ENABLE)) state_d = ST_READY;
            end
            ST_READY: begin
                if (cmd_valid) begin
                    if (cmd_op_e == OP_DISABLE)           state_d = ST_DORMANT;
                    else if (wants_engine && !refuse)     state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: state_d = ST_RUN;
            ST_RUN: begin
                if (!eng_busy) state_d = ST_READY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DORMANT;
        else     state_q <= state_d;
    end

    // Command context, sticky error flag and pin mode
    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag_q <= 1'b0;
            od_q       <= 1'b0;
            op_q       <= OP_READ;
            sector_q   <= '0;
        end else begin
            unique case (state_q)
                ST_DORMANT: begin
                    if (cmd_valid && (cmd_op_e == OP_ENABLE)) od_q <= cmd_od;
                end
                ST_READY: begin
                    if (cmd_valid) begin
                        unique case (cmd_op_e)
                            OP_ENABLE:  od_q <= cmd_od;
                            OP_DISABLE: begin
                                err_flag_q <= 1'b0;
                                od_q       <= 1'b0;
                            end
                            OP_CLEAR:   err_flag_q <= 1'b0;
                            default: begin
                                if (refuse) begin
                                    err_flag_q <= 1'b1;
                                end else begin
                                    op_q     <= cmd_op_e;
                                    sector_q <= cmd_sector;
                                end
                            end
                        endcase
                    end
                end
                ST_LAUNCH: ;
                ST_RUN: begin
                    if (op_done && eng_error) err_flag_q <= 1'b1;
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        eng_start = (state_q == ST_LAUNCH);
        eng_op    = op_q;
        eng_sector = sector_q;
        pins_on   = (state_q != ST_DORMANT);
        pin_level[PIN_STAT] = (state_q == ST_READY) && !sec_wr_busy;
        pin_level[PIN_ERR]  = !err_flag_q;
    end

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        isc_pin_drv u_drv (
            .pins_on (pins_on),
            .od_mode (od_q),
            .level   (pin_level[g]),
            .pin_o   (pin_o[g]),
            .pin_oe  (pin_oe[g])
        );
    end

    assign stat_o  = pin_o[PIN_STAT];
    assign stat_oe = pin_oe[PIN_STAT];
    assign err_o   = pin_o[PIN_ERR];
    assign err_oe  = pin_oe[PIN_ERR];

endmodule

// File: rtl/isc_cmd_gate_chk.sv
module isc_cmd_gate_chk
    import isc_gate_pkg::*;
#(
    parameter int SECTORS = 8,
    localparam int SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input logic               clk,
    input logic               rst,
    input gate_state_e        state_q,
    input logic               cmd_valid,
    input isc_op_e            cmd_op_e,
    input logic               eng_busy,
    input logic               eng_start,
    input logic [2:0]         eng_op,
    input logic [SECT_W-1:0]  eng_sector,
    input logic               secure_q,
    input logic [SECTORS-1:0] protect_q,
    input logic               od_q,
    input logic               err_flag_q,
    input logic               stat_o,
    input logic               stat_oe,
    input logic               err_o,
    input logic               err_oe
);

    assert_pins_off_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DORMANT) |-> (!stat_oe && !err_oe));

    assert_od_no_high_R2: assert property (@(posedge clk) disable iff (rst)
        ((state_q != ST_DORMANT) && od_q) |-> (!stat_o && !err_o));

    assert_pp_driven_R2: assert property (@(posedge clk) disable iff (rst)
        ((state_q != ST_DORMANT) && !od_q) |-> (stat_oe && err_oe));

    assert_run_status_low_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> !(stat_oe && stat_o));

    assert_single_start_R4: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    assert_err_pin_low_R5: assert property (@(posedge clk) disable iff (rst)
        (err_flag_q && (state_q != ST_DORMANT)) |-> (err_oe && !err_o));

    assert_clear_releases_R6: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_READY) && cmd_valid && (cmd_op_e == OP_CLEAR)) |=> !err_flag_q);

    assert_lock_chip_only_R7: assert property (@(posedge clk) disable iff (rst)
        (eng_start && secure_q) |-> (eng_op == OP_CHIP_ERASE));

    assert_protect_erase_R9: assert property (@(posedge clk) disable iff (rst)
        (eng_start && (eng_op == OP_SECT_ERASE)) |-> !protect_q[eng_sector]);

    assert_busy_keeps_err_R10: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RUN) && eng_busy && err_flag_q) |=> err_flag_q);

endmodule

bind isc_cmd_gate isc_cmd_gate_chk #(.SECTORS(SECTORS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .cmd_valid  (cmd_valid),
    .cmd_op_e   (cmd_op_e),
    .eng_busy   (eng_busy),
    .eng_start  (eng_start),
    .eng_op     (eng_op),
    .eng_sector (eng_sector),
    .secure_q   (secure_q),
    .protect_q  (protect_q),
    .od_q       (od_q),
    .err_flag_q (err_flag_q),
    .stat_o     (stat_o),
    .stat_oe    (stat_oe),
    .err_o      (err_o),
    .err_oe     (err_oe)
);

// File: tb/isc_cmd_gate_test.sv
module isc_cmd_gate_test;

    localparam int SECTORS = 8;
    localparam int SW = 3;
    localparam int LAT = 3;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] sec;
        logic       fail;
        logic       exp_start;
        logic       exp_err_low;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 3'd2, 1'b0, 1'b1, 1'b0},
        '{3'd4, 3'd1, 1'b0, 1'b1, 1'b0},
        '{3'd4, 3'd5, 1'b0, 1'b0, 1'b1},
        '{3'd2, 3'd0, 1'b0, 1'b0, 1'b0},
        '{3'd3, 3'd5, 1'b0, 1'b1, 1'b0},
        '{3'd6, 3'd0, 1'b1, 1'b1, 1'b1},
        '{3'd7, 3'd3, 1'b0, 1'b1, 1'b1},
        '{3'd2, 3'd0, 1'b0, 1'b0, 1'b0},
        '{3'd4, 3'd6, 1'b1, 1'b1, 1'b1},
        '{3'd0, 3'd0, 1'b0, 1'b0, 1'b1},
        '{3'd2, 3'd0, 1'b0, 1'b0, 1'b0},
        '{3'd7, 3'd7, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [SW-1:0] cmd_sector = '0;
    logic cmd_od = 1'b0;
    logic cfg_load = 1'b0;
    logic cfg_secure = 1'b0;
    logic [SECTORS-1:0] cfg_protect = '0;
    logic eng_busy;
    logic eng_error;
    logic sec_wr_busy = 1'b0;
    logic eng_start;
    logic [2:0] eng_op;
    logic [SW-1:0] eng_sector;
    logic stat_o, stat_oe, err_o, err_oe;

    int checks = 0;
    int errors = 0;
    logic fail_next = 1'b0;
    logic fail_q;
    int   cnt;

    always #4 clk = ~clk;

    isc_cmd_gate #(.SECTORS(SECTORS)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .cmd_od(cmd_od), .cfg_load(cfg_load),
        .cfg_secure(cfg_secure), .cfg_protect(cfg_protect), .eng_busy(eng_busy),
        .eng_error(eng_error), .sec_wr_busy(sec_wr_busy), .eng_start(eng_start),
        .eng_op(eng_op), .eng_sector(eng_sector), .stat_o(stat_o), .stat_oe(stat_oe),
        .err_o(err_o), .err_oe(err_oe)
    );

    // Engine model: busy from the cycle after start for LAT cycles
    always @(posedge clk) begin
        if (rst) begin
            eng_busy <= 1'b0;
            fail_q   <= 1'b0;
            cnt      <= 0;
        end else if (eng_start) begin
            eng_busy <= 1'b1;
            cnt      <= LAT - 1;
            fail_q   <= fail_next;
        end else if (eng_busy) begin
            if (cnt == 0) eng_busy <= 1'b0;
            else          cnt <= cnt - 1;
        end
    end
    assign eng_error = fail_q;

    function automatic logic line(input logic o, input logic oe);
        return oe ? o : 1'b1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Called at a negedge; returns at the negedge after the capturing edge
    task automatic issue(input logic [2:0] op, input logic [2:0] sec, input logic od);
        cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec; cmd_od = od;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic load_cfg(input logic sec_bit, input logic [SECTORS-1:0] prot);
        cfg_load = 1'b1; cfg_secure = sec_bit; cfg_protect = prot;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!line(stat_o, stat_oe) && n < 60) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state and dormant pins
        check("R1 stat_oe after reset", stat_oe, 0);
        check("R1 err_oe after reset", err_oe, 0);
        check("R11 no start after reset", eng_start, 0);
        issue(3'd3, 3'd0, 1'b0);
        check("R1 program ignored before enable", eng_start, 0);
        check("R1 pins still off", {stat_oe, err_oe}, 0);

        load_cfg(1'b0, 8'h20);
        issue(3'd0, 3'd0, 1'b0);
        check("R2 push-pull drive after enable", {stat_oe, stat_o, err_oe, err_o}, 4'hF);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic st;
            logic [2:0] op_seen;
            logic [2:0] sec_seen;
            fail_next = VECS[i].fail;
            issue(VECS[i].op, VECS[i].sec, 1'b0);
            st = eng_start; op_seen = eng_op; sec_seen = eng_sector;
            check($sformatf("R4/R7/R9 start vec %0d", i), st, VECS[i].exp_start);
            if (st) begin
                check($sformatf("R4 op vec %0d", i), op_seen, VECS[i].op);
                check($sformatf("R4 sector vec %0d", i), sec_seen, VECS[i].sec);
            end
            wait_ready(n);
            check($sformatf("R3 ready after vec %0d", i), line(stat_o, stat_oe), 1);
            check($sformatf("R5/R6/R9 err line vec %0d", i), !line(err_o, err_oe), VECS[i].exp_err_low);
        end
        fail_next = 1'b0;

        // R3 exact busy window
        issue(3'd3, 3'd1, 1'b0);
        check("R3 status low in launch", line(stat_o, stat_oe), 0);
        wait_ready(n);
        check("R3 busy window length", n, LAT + 2);

        // R3 secondary write busy
        sec_wr_busy = 1'b1;
        @(negedge clk);
        check("R3 low during secondary write", line(stat_o, stat_oe), 0);
        sec_wr_busy = 1'b0;
        @(negedge clk);
        check("R3 high after secondary write", line(stat_o, stat_oe), 1);

        // R10 commands while busy
        issue(3'd4, 3'd5, 1'b0);
        check("R9 protected erase flags error", !line(err_o, err_oe), 1);
        issue(3'd3, 3'd1, 1'b0);
        check("R10 accepted start", eng_start, 1);
        issue(3'd2, 3'd0, 1'b0);
        check("R10 clear in launch no start", eng_start, 0);
        check("R10 clear in launch keeps err", !line(err_o, err_oe), 1);
        issue(3'd3, 3'd2, 1'b0);
        check("R10 program in run no start", eng_start, 0);
        wait_ready(n);
        check("R10 no late start", eng_start, 0);
        check("R10 err still low after run", !line(err_o, err_oe), 1);
        issue(3'd2, 3'd0, 1'b0);
        check("R6 clear releases err", line(err_o, err_oe), 1);

        // R6 disable, then R2 open-drain
        issue(3'd4, 3'd5, 1'b0);
        issue(3'd1, 3'd0, 1'b0);
        check("R6 disable turns pins off", {stat_oe, err_oe}, 0);
        issue(3'd0, 3'd0, 1'b1);
        check("R6 err released by disable", line(err_o, err_oe), 1);
        check("R2 od idle pins released", {stat_oe, stat_o, err_oe, err_o}, 0);
        issue(3'd4, 3'd5, 1'b0);
        check("R2 od err pulls low", {err_oe, err_o}, 2'b10);
        issue(3'd3, 3'd0, 1'b0);
        check("R2 od status pulls low while busy", {stat_oe, stat_o}, 2'b10);
        wait_ready(n);
        check("R2 od status released when ready", stat_oe, 0);
        issue(3'd2, 3'd0, 1'b0);

        // R7 / R8 security
        issue(3'd1, 3'd0, 1'b0);
        load_cfg(1'b1, 8'h20);
        issue(3'd0, 3'd0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            logic [2:0] op;
            op = (k == 0) ? 3'd3 : (k == 1) ? 3'd4 : (k == 2) ? 3'd6 : 3'd7;
            issue(op, 3'd0, 1'b0);
            check($sformatf("R7 locked op %0d no start", op), eng_start, 0);
            check($sformatf("R7 locked op %0d err", op), !line(err_o, err_oe), 1);
            issue(3'd2, 3'd0, 1'b0);
        end
        fail_next = 1'b1;
        issue(3'd5, 3'd0, 1'b0);
        check("R7 chip erase accepted while locked", eng_start, 1);
        wait_ready(n);
        fail_next = 1'b0;
        check("R5 failed chip erase err", !line(err_o, err_oe), 1);
        issue(3'd2, 3'd0, 1'b0);
        issue(3'd7, 3'd0, 1'b0);
        check("R8 lock kept after failed chip erase", eng_start, 0);
        issue(3'd2, 3'd0, 1'b0);
        issue(3'd5, 3'd0, 1'b0);
        wait_ready(n);
        check("R8 chip erase ok no err", line(err_o, err_oe), 1);
        issue(3'd7, 3'd0, 1'b0);
        check("R8 read accepted after unlock", eng_start, 1);
        wait_ready(n);

        // R11 config load ignored while enabled
        load_cfg(1'b1, 8'h00);
        issue(3'd7, 3'd0, 1'b0);
        check("R11 cfg load ignored when enabled", eng_start, 1);
        wait_ready(n);

        // R11 reset keeps configuration
        issue(3'd1, 3'd0, 1'b0);
        load_cfg(1'b1, 8'h20);
        issue(3'd0, 3'd0, 1'b1);
        issue(3'd7, 3'd0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R11 pins off after reset", {stat_oe, err_oe}, 0);
        issue(3'd0, 3'd0, 1'b0);
        check("R11 err cleared by reset", line(err_o, err_oe), 1);
        check("R11 push-pull after reenable", {stat_oe, err_oe}, 2'b11);
        issue(3'd7, 3'd0, 1'b0);
        check("R11 lock kept over reset", eng_start, 0);
        issue(3'd2, 3'd0, 1'b0);
        issue(3'd5, 3'd0, 1'b0);
        wait_ready(n);
        issue(3'd4, 3'd5, 1'b0);
        check("R11 protect kept over reset", eng_start, 0);
        issue(3'd4, 3'd4, 1'b0);
        check("R9 unprotected erase accepted", eng_start, 1);
        wait_ready(n);

        summary();
        $finish;
    end

endmodule